// File: doc/BRIEF.md
# Region Freeze Bus Bridge

This block sits on the bus branch between the static part of a device and a single reconfigurable region. It passes request/response traffic between the two sides while the region is in use. On command from a host control register it isolates the region so that the region can be reprogrammed without disturbing the rest of the device. Traffic on other branches never passes through this block and is not affected by it.

A freeze command stops the bridge from taking new requests. Requests already forwarded to the region still get their responses. Once no request is outstanding, every signal crossing the boundary in either direction is forced to zero and the status shows the bridge as frozen. An unfreeze command releases the clamps on the next clock, and the status shows the bridge as running one cycle later. A reconfiguration sequencer polls the status bits, so it can place its own limit on how long each transition may take. Reset leaves the bridge frozen, so an unconfigured region cannot put traffic on the static bus.

Top module: `region_freeze_bridge`

## Requirements
- R1: In the first cycle after reset, `ctl_status` reads 2'b01 (bit 0 frozen = 1, bit 1 running = 0), and every boundary output is zero whatever the inputs are.
- R2: While frozen, no handshake can complete in either direction: `s_req_ready`, `s_rsp_valid`, `r_req_valid` and `r_rsp_ready` are all 0.
- R3: While frozen, the payload outputs `r_req_write`, `r_req_addr`, `r_req_wdata` and `s_rsp_rdata` are held at all zeros.
- R4: While running, a request passes combinationally from the static side to the region (valid, write, addr, wdata forward; ready back). A response passes from the region to the static side (valid, rdata forward; ready back).
- R5: A control write with bit 0 (freeze) set while running drops `s_req_ready` and `r_req_valid` from the next cycle on. Responses to requests already accepted are still delivered.
- R6: After a freeze command, the frozen status bit rises on the clock edge that ends the first draining cycle in which no request is outstanding. With nothing outstanding at the command, it reads 1 two cycles after the write cycle.
- R7: A control write with bit 1 (unfreeze) set while frozen releases the clamps in the cycle after the write. The running status bit reads 1 one cycle after that.
- R8: A freeze command while draining or frozen, and an unfreeze command while running, releasing or draining, leave the state and status unchanged. When both bits are written together, only the command valid in the current state takes effect.
- R9: At most `MAX_OUTST` requests can be outstanding. When that many are outstanding, `s_req_ready` and `r_req_valid` are 0. A region response is passed to the static side only while at least one request is outstanding.
- R10: `ctl_status` bit 0 (frozen) and bit 1 (running) are never 1 together. Both read 0 while draining and while releasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 2 | Bit 0 freeze command, bit 1 unfreeze command |
| ctl_status | output | 2 | Bit 0 frozen, bit 1 running |
| s_req_valid | input | 1 | Request valid from static side |
| s_req_ready | output | 1 | Request ready to static side |
| s_req_write | input | 1 | Request is a write |
| s_req_addr | input | ADDR_W | Request address |
| s_req_wdata | input | DATA_W | Request write data |
| s_rsp_valid | output | 1 | Response valid to static side |
| s_rsp_ready | input | 1 | Response ready from static side |
| s_rsp_rdata | output | DATA_W | Response data to static side |
| r_req_valid | output | 1 | Request valid to region |
| r_req_ready | input | 1 | Request ready from region |
| r_req_write | output | 1 | Request is a write, to region |
| r_req_addr | output | ADDR_W | Request address to region |
| r_req_wdata | output | DATA_W | Request write data to region |
| r_rsp_valid | input | 1 | Response valid from region |
| r_rsp_ready | output | 1 | Response ready to region |
| r_rsp_rdata | input | DATA_W | Response data from region |

## Verification
The assertions check on every cycle that frozen means all boundary outputs are zero, and that draining blocks new requests. They also check that the status bits are exclusive, that the counter never overflows or underflows, that freezing cannot complete while requests are outstanding, and that the release state always lasts one cycle. Only the bench scenarios can show the exact cycle on which each status bit changes after a control write. The same holds for payloads that pass unchanged while running, responses delivered during a drain, and commands ignored in the wrong state.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    // control word bit positions
    localparam int CMD_FREEZE_BIT   = 0;
    localparam int CMD_UNFREEZE_BIT = 1;
    localparam int CTL_W            = 2;

    // status word bit positions
    localparam int ST_FROZEN_BIT    = 0;
    localparam int ST_RUNNING_BIT   = 1;

    typedef enum logic [1:0] {
        GATE_RUN    = 2'd0,
        GATE_DRAIN  = 2'd1,
        GATE_FROZEN = 2'd2,
        GATE_THAW   = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic freeze;
        logic unfreeze;
    } ctl_cmd_t;

    function automatic ctl_cmd_t decode_cmd(input logic wr, input logic [CTL_W-1:0] d);
        ctl_cmd_t c;
        c.freeze   = wr & d[CMD_FREEZE_BIT];
        c.unfreeze = wr & d[CMD_UNFREEZE_BIT];
        return c;
    endfunction

    // new requests may be taken
    function automatic logic takes_requests(input gate_state_e s);
        return (s == GATE_RUN) || (s == GATE_THAW);
    endfunction

    // responses may cross
    function automatic logic passes_responses(input gate_state_e s);
        return (s != GATE_FROZEN);
    endfunction

endpackage

// File: rtl/rfb_ctrl.sv
module rfb_ctrl
    import rfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CTL_W-1:0]  cmd_data,
    input  logic              idle,
    output gate_state_e       state_q,
    output logic [1:0]        status
);

    ctl_cmd_t    cmd;
    gate_state_e state_d;

    always_comb begin
        cmd     = decode_cmd(cmd_wr, cmd_data);
        state_d = state_q;
        unique case (state_q)
            GATE_RUN:    if (cmd.freeze)   state_d = GATE_DRAIN;
            GATE_DRAIN:  if (idle)         state_d = GATE_FROZEN;
            GATE_FROZEN: if (cmd.unfreeze) state_d = GATE_THAW;
            GATE_THAW:                     state_d = GATE_RUN;
            default:                       state_d = GATE_FROZEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_FROZEN;
        else     state_q <= state_d;
    end

    always_comb begin
        status                 = '0;
        status[ST_FROZEN_BIT]  = (state_q == GATE_FROZEN);
        status[ST_RUNNING_BIT] = (state_q == GATE_RUN);
    end

    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(status[ST_FROZEN_BIT] && status[ST_RUNNING_BIT]));

    // R6
    no_early_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_DRAIN && !idle) |=> (state_q != GATE_FROZEN));

    // R7
    thaw_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_THAW) |=> (state_q == GATE_RUN));

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_FROZEN && !(cmd_wr && cmd_data[CMD_UNFREEZE_BIT]))
        |=> (state_q == GATE_FROZEN));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_RUN && !(cmd_wr && cmd_data[CMD_FREEZE_BIT]))
        |=> (state_q == GATE_RUN));

endmodule

// File: rtl/rfb_tracker.sv
module rfb_tracker #(
    parameter int MAX_OUTST = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic retire,
    output logic idle,
    output logic full
);

    localparam int CNT_W = $clog2(MAX_OUTST + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTST);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case ({accept, retire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign idle = (count_q == '0);
    assign full = (count_q == CNT_MAX);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !accept);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !retire);

endmodule

// File: rtl/rfb_clamp.sv
module rfb_clamp #(
    parameter int W = 1
) (
    input  logic         pass,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    assign dout = pass ? din : '0;

endmodule

// File: rtl/region_freeze_bridge.sv
module region_freeze_bridge
    import rfb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MAX_OUTST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [1:0]        ctl_wr_data,
    output logic [1:0]        ctl_status,
    input  logic              s_req_valid,
    output logic              s_req_ready,
    input  logic              s_req_write,
    input  logic [ADDR_W-1:0] s_req_addr,
    input  logic [DATA_W-1:0] s_req_wdata,
    output logic              s_rsp_valid,
    input  logic              s_rsp_ready,
    output logic [DATA_W-1:0] s_rsp_rdata,
    output logic              r_req_valid,
    input  logic              r_req_ready,
    output logic              r_req_write,
    output logic [ADDR_W-1:0] r_req_addr,
    output logic [DATA_W-1:0] r_req_wdata,
    input  logic              r_rsp_valid,
    output logic              r_rsp_ready,
    input  logic [DATA_W-1:0] r_rsp_rdata
);

    localparam int REQ_FW = 2 + ADDR_W + DATA_W;
    localparam int RSP_FW = 1 + DATA_W;

    gate_state_e state;
    logic        idle, full;
    logic        req_pass, rsp_pass;
    logic        accept, retire;

    rfb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (ctl_wr_en),
        .cmd_data (ctl_wr_data),
        .idle     (idle),
        .state_q  (state),
        .status   (ctl_status)
    );

    rfb_tracker #(.MAX_OUTST(MAX_OUTST)) u_track (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .retire (retire),
        .idle   (idle),
        .full   (full)
    );

    assign req_pass = takes_requests(state) && !full;
    assign rsp_pass = passes_responses(state) && !idle;

    // request path toward region
    logic [REQ_FW-1:0] req_fwd_in, req_fwd_out;
    assign req_fwd_in = {s_req_valid, s_req_write, s_req_addr, s_req_wdata};

    rfb_clamp #(.W(REQ_FW)) u_req_fwd (
        .pass (req_pass),
        .din  (req_fwd_in),
        .dout (req_fwd_out)
    );
    assign {r_req_valid, r_req_write, r_req_addr, r_req_wdata} = req_fwd_out;

    rfb_clamp #(.W(1)) u_req_bwd (
        .pass (req_pass),
        .din  (r_req_ready),
        .dout (s_req_ready)
    );

    // response path toward static side
    logic [RSP_FW-1:0] rsp_fwd_in, rsp_fwd_out;
    assign rsp_fwd_in = {r_rsp_valid, r_rsp_rdata};

    rfb_clamp #(.W(RSP_FW)) u_rsp_fwd (
        .pass (rsp_pass),
        .din  (rsp_fwd_in),
        .dout (rsp_fwd_out)
    );
    assign {s_rsp_valid, s_rsp_rdata} = rsp_fwd_out;

    rfb_clamp #(.W(1)) u_rsp_bwd (
        .pass (rsp_pass),
        .din  (s_rsp_ready),
        .dout (r_rsp_ready)
    );

    assign accept = s_req_valid && s_req_ready;
    assign retire = s_rsp_valid && s_rsp_ready;

    // R2
    frozen_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_status[ST_FROZEN_BIT] |->
        !(s_req_ready || s_rsp_valid || r_req_valid || r_rsp_ready));

    // R3
    frozen_payload_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_status[ST_FROZEN_BIT] |->
        (r_req_write == 1'b0 && r_req_addr == '0 && r_req_wdata == '0 && s_rsp_rdata == '0));

    // R5
    drain_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_DRAIN) |-> (!s_req_ready && !r_req_valid));

    // R4
    run_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_status[ST_RUNNING_BIT] && !full) |->
        (r_req_valid == s_req_valid && r_req_addr == s_req_addr && s_req_ready == r_req_ready));

endmodule

// File: tb/region_freeze_bridge_tb.sv
module region_freeze_bridge_tb_top;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MO = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_wr_en;
    logic [1:0]    ctl_wr_data;
    logic [1:0]    ctl_status;
    logic          s_req_valid, s_req_ready, s_req_write;
    logic [AW-1:0] s_req_addr;
    logic [DW-1:0] s_req_wdata;
    logic          s_rsp_valid, s_rsp_ready;
    logic [DW-1:0] s_rsp_rdata;
    logic          r_req_valid, r_req_ready, r_req_write;
    logic [AW-1:0] r_req_addr;
    logic [DW-1:0] r_req_wdata;
    logic          r_rsp_valid, r_rsp_ready;
    logic [DW-1:0] r_rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    region_freeze_bridge #(.ADDR_W(AW), .DATA_W(DW), .MAX_OUTST(MO)) dut_i (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_status(ctl_status),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
        .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready), .s_rsp_rdata(s_rsp_rdata),
        .r_req_valid(r_req_valid), .r_req_ready(r_req_ready), .r_req_write(r_req_write),
        .r_req_addr(r_req_addr), .r_req_wdata(r_req_wdata),
        .r_rsp_valid(r_rsp_valid), .r_rsp_ready(r_rsp_ready), .r_rsp_rdata(r_rsp_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctl_wr_en = 0; ctl_wr_data = 0;
        s_req_valid = 0; s_req_write = 0; s_req_addr = 0; s_req_wdata = 0;
        s_rsp_ready = 0; r_req_ready = 0; r_rsp_valid = 0; r_rsp_rdata = 0;
    endtask

    task automatic ctl_write(input logic [1:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = 2'b00;
    endtask

    // all boundary outputs zero
    task automatic check_clamped(input string req);
        check(req, {s_req_ready, s_rsp_valid, r_req_valid, r_rsp_ready}, 4'b0000);
        check(req, {r_req_write, r_req_addr, r_req_wdata, s_rsp_rdata}, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_inputs();
        s_req_valid = 1; s_req_write = 1; s_req_addr = 16'hBEEF; s_req_wdata = 32'hCAFE0001;
        r_req_ready = 1; r_rsp_valid = 1; r_rsp_rdata = 32'h12345678; s_rsp_ready = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 status after reset", ctl_status, 2'b01);
        check_clamped("R1 R2 R3 clamped after reset");
        idle_inputs();
    endtask

    task automatic t_unfreeze();
        ctl_write(2'b10);
        s_req_valid = 1; s_req_addr = 16'h0042; s_req_wdata = 32'h55AA55AA;
        #1;
        check("R10 status during release", ctl_status, 2'b00);
        check("R7 clamp released next cycle", {r_req_valid, r_req_addr}, {1'b1, 16'h0042});
        @(negedge clk);
        s_req_valid = 0;
        #1;
        check("R7 running one cycle later", ctl_status, 2'b10);
    endtask

    task automatic t_pass();
        @(negedge clk);
        s_req_valid = 1; s_req_write = 1; s_req_addr = 16'h1234; s_req_wdata = 32'hA5A5F00D;
        r_req_ready = 1;
        #1;
        check("R4 request forwarded", {r_req_valid, r_req_write, r_req_addr, r_req_wdata},
              {1'b1, 1'b1, 16'h1234, 32'hA5A5F00D});
        check("R4 ready returned", s_req_ready, 1'b1);
        @(negedge clk);
        s_req_valid = 0; r_req_ready = 0;
        r_rsp_valid = 1; r_rsp_rdata = 32'h0BADC0DE; s_rsp_ready = 1;
        #1;
        check("R4 response forwarded", {s_rsp_valid, s_rsp_rdata, r_rsp_ready},
              {1'b1, 32'h0BADC0DE, 1'b1});
        @(negedge clk);
        r_rsp_valid = 0; s_rsp_ready = 0;
        r_rsp_valid = 1;
        #1;
        check("R9 stray response blocked when none outstanding", s_rsp_valid, 1'b0);
        r_rsp_valid = 0;
    endtask

    task automatic t_drain();
        @(negedge clk);
        s_req_valid = 1; r_req_ready = 1; s_req_addr = 16'h0777;
        @(negedge clk);
        s_req_valid = 0; r_req_ready = 0;
        ctl_write(2'b01);
        s_req_valid = 1; r_req_ready = 1;
        #1;
        check("R5 new request blocked while draining", {s_req_ready, r_req_valid}, 2'b00);
        s_req_valid = 0; r_req_ready = 0;
        ctl_wr_en = 1; ctl_wr_data = 2'b10;
        @(negedge clk);
        ctl_wr_en = 0; ctl_wr_data = 2'b00;
        #1;
        check("R6 R8 still draining with request outstanding", ctl_status, 2'b00);
        r_rsp_valid = 1; r_rsp_rdata = 32'hFEEDFACE; s_rsp_ready = 1;
        #1;
        check("R5 response delivered during drain", {s_rsp_valid, s_rsp_rdata}, {1'b1, 32'hFEEDFACE});
        @(negedge clk);
        r_rsp_valid = 0; s_rsp_ready = 0;
        #1;
        check("R6 not frozen on retire edge", ctl_status, 2'b00);
        @(negedge clk);
        #1;
        check("R6 frozen after idle drain cycle", ctl_status, 2'b01);
    endtask

    task automatic t_ignore_frozen();
        ctl_write(2'b01);
        @(negedge clk);
        s_req_valid = 1; r_req_ready = 1; r_rsp_valid = 1; s_rsp_ready = 1;
        s_req_addr = 16'hFFFF; r_rsp_rdata = 32'hFFFFFFFF;
        #1;
        check("R8 freeze ignored while frozen", ctl_status, 2'b01);
        check_clamped("R2 R3 clamped while frozen");
        idle_inputs();
    endtask

    task automatic t_both_bits();
        ctl_write(2'b11);
        #1;
        check("R8 both bits in frozen -> release", ctl_status, 2'b00);
        @(negedge clk);
        #1;
        check("R8 both bits reach running", ctl_status, 2'b10);
        ctl_write(2'b10);
        @(negedge clk);
        #1;
        check("R8 unfreeze ignored while running", ctl_status, 2'b10);
    endtask

    task automatic t_limit();
        @(negedge clk);
        s_req_valid = 1; r_req_ready = 1;
        repeat (MO) @(negedge clk);
        #1;
        check("R9 request blocked at limit", {s_req_ready, r_req_valid}, 2'b00);
        s_req_valid = 0; r_req_ready = 0;
        r_rsp_valid = 1; s_rsp_ready = 1;
        repeat (MO) @(negedge clk);
        #1;
        check("R9 responses stop after all retired", s_rsp_valid, 1'b0);
        r_rsp_valid = 0; s_rsp_ready = 0;
    endtask

    task automatic t_freeze_idle();
        ctl_write(2'b01);
        #1;
        check("R6 draining one cycle after command", ctl_status, 2'b00);
        @(negedge clk);
        #1;
        check("R6 frozen two cycles after command", ctl_status, 2'b01);
    endtask

    initial begin
        t_reset();
        t_unfreeze();
        t_pass();
        t_drain();
        t_ignore_frozen();
        t_both_bits();
        t_limit();
        t_freeze_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule